// File: doc/BRIEF.md
# APB Watchdog Timer

This peripheral guards a system against software that has stopped running. A down-counter is loaded from a programmable reload value and decrements while the timer is enabled. Software keeps the system alive by writing a fixed key word to a restart register, which copies the reload value back into the counter. If the counter is allowed to reach zero, a sticky status flag is set. Up to three outputs then fire together: a system reset request, an interrupt and an external signal. Each output has its own enable. All three stay asserted for one shared, programmable number of bus cycles.

The counter either steps on every bus clock or steps once per rising edge of a slow external tick. That tick is brought into the bus clock domain through a two-flop synchroniser with edge detection. Its period must exceed two bus clock periods. All registers sit behind a zero-wait APB-style slave interface with word-aligned addresses. Any address with non-zero low bits is ignored on writes and reads as zero.

Top module: `wdog_apb`

## Requirements
- R1: After reset the counter reads 0, reload reads 0x03EF1480, control reads 0, status reads 0, pulse length reads 0xFF, and all three outputs are low.
- R2: Register word offsets are: 0x00 counter (read-only), 0x04 reload, 0x08 restart, 0x0C control, 0x10 status, 0x14 clear, 0x18 pulse length. Reads of restart and clear return 0. Writes to the counter offset leave the counter unchanged.
- R3: With control bit 0 (run) set and bit 4 (source) clear, the counter decrements by one on each bus clock edge. If a control write loads reload value N, the outputs first go high on the N-th clock edge after that write.
- R4: Clearing run stops the counter, and it holds its value.
- R5: Writing exactly 0x5AB9 to the restart register loads the reload value into the counter, whether or not run is set. A write of any other value to the restart register has no effect.
- R6: A control write with bit 0 set loads the reload value only when the counter is zero. With a non-zero counter, counting continues from the present value.
- R7: Status bit 0 is set when a step takes the counter from 1 to 0. It stays set until software writes clear with bit 0 = 1. A clear write with bit 0 = 0 has no effect. If a set and a clear land in the same cycle, the set wins.
- R8: On expiry, the enabled outputs go high together for exactly L bus cycles, where L is the pulse-length value. The enables are control bit 1 (reset output), bit 2 (interrupt) and bit 3 (external output). A disabled output stays low.
- R9: After expiry the counter stays at zero until it is restarted or reloaded by a control write.
- R10: With pulse length 0, an expiry sets status but asserts no output.
- R11: With control bit 4 set, the counter decrements once per rising edge of the external tick, after a two-flop synchroniser. Without tick edges it does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 5 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational, zero-wait) |
| ext_tick | input | 1 | Slow external count source (asynchronous) |
| sys_rst_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Interrupt pulse |
| ext_o | output | 1 | External signal pulse |

## Verification
Register writes take effect on the clock edge that ends the access phase. Read data is combinational, so the bench samples it in the access phase, two nanoseconds after the falling edge. The outputs follow expiry with no added register. Output timing is therefore measured by counting falling edges after the write that started the counter: for a load value N, the first high sample is the N-th one and the high run lasts L samples. An external tick edge reaches the counter on the second or third clock edge after it rises. For that reason, counter reads in tick mode are made only after several idle cycles, once the decrement has certainly landed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned CNT_W_DEF = 32;
    localparam int unsigned LEN_W_DEF = 8;

    localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_5AB9;
    localparam logic [DATA_W-1:0] RELOAD_RST  = 32'h03EF_1480;
    localparam logic [DATA_W-1:0] LEN_RST     = 32'h0000_00FF;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic tick_src;   // bit 4
        logic ext_en;     // bit 3
        logic irq_en;     // bit 2
        logic rst_en;     // bit 1
        logic run;        // bit 0
    } wd_ctrl_t;

    localparam int unsigned CTRL_W = $bits(wd_ctrl_t);

    typedef enum logic [2:0] {
        RG_COUNT  = 3'd0,
        RG_RELOAD = 3'd1,
        RG_KICK   = 3'd2,
        RG_CTRL   = 3'd3,
        RG_STAT   = 3'd4,
        RG_CLR    = 3'd5,
        RG_LEN    = 3'd6,
        RG_NONE   = 3'd7
    } wd_reg_e;

    function automatic wd_reg_e decode_reg(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return RG_NONE;
        return wd_reg_e'(a[4:2]);
    endfunction

endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    output logic tick_pulse
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], tick_in};
    end

    assign tick_pulse = sh[1] & ~sh[2];

    // R11
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick_pulse |=> !tick_pulse);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign hit = step && !load && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst)                         cnt <= '0;
        else if (load)                   cnt <= load_val;
        else if (step && cnt != '0)      cnt <= cnt - ONE;
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE));
    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(cnt));
    // R9
    cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !load) |=> (cnt == '0));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [LEN_W-1:0] len,
    output logic             active
);
    logic [LEN_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)                left <= '0;
        else if (fire)          left <= len;
        else if (left != '0)    left <= left - LEN_W'(1);
    end

    assign active = (left != '0);

    // R8
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (left == $past(len)));
    // R10
    pulse_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && len == '0) |=> !active);
endmodule

// File: rtl/wdog_apb.sv
module wdog_apb
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF,
    parameter int unsigned LEN_W = LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              ext_tick,
    output logic              sys_rst_o,
    output logic              irq_o,
    output logic              ext_o
);
    wd_reg_e          sel;
    logic             wr;
    wd_ctrl_t         ctrl;
    wd_ctrl_t         ctrl_new;
    logic [CNT_W-1:0] reload;
    logic [LEN_W-1:0] plen;
    logic             status;
    logic [CNT_W-1:0] cnt;
    logic             hit, load, step, tick_pulse, active;
    logic             kick, ctrl_wr, clr_wr;

    assign sel      = decode_reg(paddr);
    assign wr       = psel && penable && pwrite;
    assign ctrl_new = wd_ctrl_t'(pwdata[CTRL_W-1:0]);
    assign kick     = wr && sel == RG_KICK && pwdata == RESTART_KEY;
    assign ctrl_wr  = wr && sel == RG_CTRL;
    assign clr_wr   = wr && sel == RG_CLR && pwdata[0];
    assign load     = kick || (ctrl_wr && ctrl_new.run && cnt == '0);
    assign step     = ctrl.run && (ctrl.tick_src ? tick_pulse : 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= RELOAD_RST[CNT_W-1:0];
            plen   <= LEN_RST[LEN_W-1:0];
        end else if (wr) begin
            if (sel == RG_CTRL)   ctrl   <= ctrl_new;
            if (sel == RG_RELOAD) reload <= pwdata[CNT_W-1:0];
            if (sel == RG_LEN)    plen   <= pwdata[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         status <= 1'b0;
        else if (hit)    status <= 1'b1;
        else if (clr_wr) status <= 1'b0;
    end

    wdog_tick_sync u_sync (
        .clk(clk), .rst(rst), .tick_in(ext_tick), .tick_pulse(tick_pulse)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(reload),
        .step(step), .cnt(cnt), .hit(hit)
    );

    wdog_pulse #(.LEN_W(LEN_W)) u_pulse (
        .clk(clk), .rst(rst), .fire(hit), .len(plen), .active(active)
    );

    assign sys_rst_o = active && ctrl.rst_en;
    assign irq_o     = active && ctrl.irq_en;
    assign ext_o     = active && ctrl.ext_en;

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                RG_COUNT:  prdata = DATA_W'(cnt);
                RG_RELOAD: prdata = DATA_W'(reload);
                RG_CTRL:   prdata = DATA_W'(ctrl);
                RG_STAT:   prdata = DATA_W'(status);
                RG_LEN:    prdata = DATA_W'(plen);
                default:   prdata = '0;
            endcase
        end
    end

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status && !clr_wr) |=> status);
    // R7
    status_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> status);
    // R5
    kick_load_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt == $past(reload)));
endmodule

// File: tb/tb_wdog_apb.sv
module tb_wdog_apb;
    import wdog_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [DATA_W-1:0] pwdata = '0;
    logic [DATA_W-1:0] prdata;
    logic              ext_tick = 1'b0;
    logic              sys_rst_o, irq_o, ext_o;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } item_t;
    item_t q[$];

    localparam logic [4:0] A_CNT = 5'h00, A_REL = 5'h04, A_KICK = 5'h08,
                           A_CTRL = 5'h0C, A_STAT = 5'h10, A_CLR = 5'h14,
                           A_LEN = 5'h18;

    always #4 clk = ~clk;

    wdog_apb dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_tick(ext_tick),
        .sys_rst_o(sys_rst_o), .irq_o(irq_o), .ext_o(ext_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.tag = tag; it.exp = exp;
        q.push_back(it);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // monitor: compares read data during the access phase
    always @(negedge clk) begin
        #2;
        if (psel && penable && !pwrite) begin
            if (q.size() == 0) chk("read with no expected item", 32'h1, 32'h0);
            else begin
                item_t it;
                it = q.pop_front();
                chk(it.tag, prdata, it.exp);
            end
        end
    end

    int f_r, w_r, f_i, w_i, f_e, w_e;

    // counts negedges after a write; first = index of first high sample
    task automatic measure(input int span);
        f_r = 0; w_r = 0; f_i = 0; w_i = 0; f_e = 0; w_e = 0;
        for (int i = 1; i <= span; i++) begin
            @(negedge clk); #1;
            if (sys_rst_o) begin if (f_r == 0) f_r = i; w_r++; end
            if (irq_o)     begin if (f_i == 0) f_i = i; w_i++; end
            if (ext_o)     begin if (f_e == 0) f_e = i; w_e++; end
        end
    endtask

    task automatic tick_once;
        @(negedge clk); ext_tick = 1'b1;
        repeat (3) @(negedge clk);
        ext_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired got running exp done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 sys_rst_o", 32'(sys_rst_o), 0);
        chk("R1 irq_o", 32'(irq_o), 0);
        chk("R1 ext_o", 32'(ext_o), 0);
        apb_rd(A_CNT,  32'h0, "R1 counter");
        apb_rd(A_REL,  32'h03EF1480, "R1 reload");
        apb_rd(A_CTRL, 32'h0, "R1 control");
        apb_rd(A_STAT, 32'h0, "R1 status");
        apb_rd(A_LEN,  32'hFF, "R1 pulse length");

        // R2 write-only reads and ignored counter write
        apb_rd(A_KICK, 32'h0, "R2 restart reads zero");
        apb_rd(A_CLR,  32'h0, "R2 clear reads zero");
        apb_wr(A_CNT, 32'h77);
        apb_rd(A_CNT, 32'h0, "R2 counter write ignored");

        // R3 / R8 all outputs, reload 6, length 3
        apb_wr(A_REL, 32'd6);
        apb_wr(A_LEN, 32'd3);
        apb_wr(A_CTRL, 32'h0F);
        measure(14);
        chk("R3 first reset pulse index", f_r, 6);
        chk("R8 reset pulse width", w_r, 3);
        chk("R8 irq first index", f_i, 6);
        chk("R8 irq width", w_i, 3);
        chk("R8 ext first index", f_e, 6);
        chk("R8 ext width", w_e, 3);
        apb_rd(A_STAT, 32'h1, "R7 status set on expiry");
        apb_rd(A_CNT, 32'h0, "R9 counter stays zero");

        // R7 clear semantics
        apb_wr(A_CLR, 32'h2);
        apb_rd(A_STAT, 32'h1, "R7 clear bit0=0 no effect");
        apb_wr(A_CLR, 32'h1);
        apb_rd(A_STAT, 32'h0, "R7 clear bit0=1 clears");

        // R5 key restart
        apb_wr(A_CTRL, 32'h0);
        apb_wr(A_KICK, 32'h1234);
        apb_rd(A_CNT, 32'h0, "R5 wrong key ignored");
        apb_wr(A_KICK, 32'h5AB9);
        apb_rd(A_CNT, 32'd6, "R5 key loads reload");

        // R4 stop holds value: 3 steps between the two writes
        apb_wr(A_CTRL, 32'h01);
        apb_wr(A_CTRL, 32'h00);
        repeat (10) @(negedge clk);
        apb_rd(A_CNT, 32'd3, "R4 counter held after stop");

        // R6 no load with non-zero counter; R8 only irq enabled
        apb_wr(A_REL, 32'd4);
        apb_wr(A_CTRL, 32'h05);
        measure(12);
        chk("R6 no reload when nonzero, irq index", f_i, 3);
        chk("R8 irq width", w_i, 3);
        chk("R8 reset output disabled", w_r, 0);
        chk("R8 ext output disabled", w_e, 0);
        apb_wr(A_CTRL, 32'h05);
        measure(12);
        chk("R6 reload when zero, irq index", f_i, 4);

        // R10 zero length
        apb_wr(A_CLR, 32'h1);
        apb_wr(A_LEN, 32'h0);
        apb_wr(A_CTRL, 32'h0F);
        measure(10);
        chk("R10 no reset pulse", w_r + w_i + w_e, 0);
        apb_rd(A_STAT, 32'h1, "R10 status still set");

        // R11 external tick source
        apb_wr(A_CTRL, 32'h0);
        apb_wr(A_KICK, 32'h5AB9);
        apb_wr(A_CTRL, 32'h11);
        repeat (10) @(negedge clk);
        apb_rd(A_CNT, 32'd4, "R11 no step without tick");
        for (int k = 0; k < 3; k++) tick_once();
        repeat (4) @(negedge clk);
        apb_rd(A_CNT, 32'd1, "R11 one step per tick edge");
        apb_wr(A_CLR, 32'h1);
        tick_once();
        repeat (4) @(negedge clk);
        apb_rd(A_CNT, 32'd0, "R11 final tick reaches zero");
        apb_rd(A_STAT, 32'h1, "R11 expiry in tick mode sets status");

        repeat (3) @(negedge clk);
        chk("scoreboard drained", q.size(), 0);
        finish_run();
    end
endmodule